// File: doc/BRIEF.md
# Oversampled Asynchronous Receiver with Split Interrupts

This block turns an asynchronous serial stream into characters. A tick at sixteen times the bit rate paces it. Each bit is sampled three times around its centre, and the majority of the three samples decides the bit value. The block hunts for a start edge, collects eight or nine character bits least significant first, and checks the stop bit. It then moves the finished character into a holding register and raises a full flag. When parity is on, the last character bit is the parity bit and is checked against the selected sense.

Status is kept in six sticky flags: full, idle, overrun, noise, framing and parity. Each flag has its own enable input. The full and idle flags drive a receive interrupt line. The overrun, noise, framing and parity flags drive a separate error interrupt line. Two strobes clear the flags. Reading the data releases the holding register and clears the error flags. The status-clear strobe drops the idle flag and the error flags but leaves the character in place.

Top module: `uart_rx_err`

## Requirements
- R1: A frame is one start bit (0), then 8 character bits (`cfg_nine`=0) or 9 character bits (`cfg_nine`=1) sent least significant bit first, then one stop bit (1). The character appears right-aligned on `rx_data`, with bit 8 equal to 0 in 8-bit mode, and `flag_full` is set.
- R2: `irq_rx` is high while `flag_full` and `en_full` are both high, or while `flag_idle` and `en_idle` are both high.
- R3: If a frame completes while `flag_full` is still set, `flag_ovr` is set, `rx_data` keeps the earlier character, and the new character is dropped.
- R4: Each bit is sampled at oversample counts 7, 8 and 9 of 16 and its value is the majority of those samples. Any disagreement in the start, character or stop bit sets `flag_noise` with the character.
- R5: After a falling edge, a start bit whose majority sample is 1 is rejected. No character results and hunting for a start bit resumes.
- R6: A stop bit sampled as 0 sets `flag_frame`. A break (all zeros) is stored as data 0 with `flag_frame` set.
- R7: With `cfg_par_en`=1, the last character bit is parity (bit 7 in 8-bit mode, bit 8 in 9-bit mode). With `cfg_par_odd`=0 the character bits including parity must hold an even number of ones, and with `cfg_par_odd`=1 an odd number. A mismatch sets `flag_par`.
- R8: After a character, once the line has stayed 1 for a full character time (160 ticks in 8-bit mode, 176 in 9-bit mode) `flag_idle` is set.
- R9: The idle flag does not set again until another character has been received. Any 0 sample restarts the idle count.
- R10: `irq_err` is the OR of each error flag (overrun, noise, framing, parity) gated by its own enable.
- R11: A `rd_data` pulse clears `flag_full` and the four error flags. A `clr_stat` pulse clears `flag_idle` and the four error flags but leaves `flag_full` and `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial data line, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_nine | input | 1 | 1 selects 9 character bits |
| cfg_par_en | input | 1 | 1 treats last character bit as parity |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| en_full | input | 1 | Full flag interrupt enable |
| en_idle | input | 1 | Idle flag interrupt enable |
| en_ovr | input | 1 | Overrun interrupt enable |
| en_noise | input | 1 | Noise interrupt enable |
| en_frame | input | 1 | Framing error interrupt enable |
| en_par | input | 1 | Parity error interrupt enable |
| rd_data | input | 1 | Data read strobe |
| clr_stat | input | 1 | Status clear strobe |
| rx_data | output | 9 | Received character |
| flag_full | output | 1 | Character waiting |
| flag_idle | output | 1 | Idle line seen |
| flag_ovr | output | 1 | Overrun |
| flag_noise | output | 1 | Noise seen in the stored frame |
| flag_frame | output | 1 | Framing error |
| flag_par | output | 1 | Parity error |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The input passes through a two-stage synchroniser, so a level driven before tick k of a bit is decided on the tick that carries count k. Character data and all frame flags are updated on the clock edge of the stop bit's count-9 tick, seven ticks before that bit ends. The interrupt lines follow the flags combinationally in the same cycle. The idle flag appears one character time of high ticks after the stop decision. The bench drives the line on falling edges, one tick-aligned level per oversample slot. It checks frame results only once the stop bit has been fully driven, and it places idle checks at least eight ticks away from the expected threshold on both sides.

// File: rtl/uart_rx_err.sv
module uart_rx_err #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       os_tick,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       en_full,
  input  logic       en_idle,
  input  logic       en_ovr,
  input  logic       en_noise,
  input  logic       en_frame,
  input  logic       en_par,
  input  logic       rd_data,
  input  logic       clr_stat,
  output logic [8:0] rx_data,
  output logic       flag_full,
  output logic       flag_idle,
  output logic       flag_ovr,
  output logic       flag_noise,
  output logic       flag_frame,
  output logic       flag_par,
  output logic       irq_rx,
  output logic       irq_err
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(OSR * 11 + 1);
  localparam logic [CW-1:0] C_LO  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_MID = CW'(OSR / 2);
  localparam logic [CW-1:0] C_HI  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] C_TOP = CW'(OSR - 1);

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  st_t           st;
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [8:0]    sh;
  logic [IW-1:0] icnt;
  logic          s_lo, s_mid, prev, nz_acc, armed;

  logic          rx_s, maj, nz, at_dec, keep_old, par_bad;
  logic [8:0]    word;
  logic [3:0]    last_bit;
  logic [IW-1:0] ilim;

  assign rx_s     = sync_q[1];
  assign maj      = (s_lo & s_mid) | (s_lo & rx_s) | (s_mid & rx_s);
  assign nz       = (s_lo != s_mid) | (s_mid != rx_s);
  assign at_dec   = (cnt == C_HI);
  assign word     = cfg_nine ? sh : {1'b0, sh[8:1]};
  assign last_bit = cfg_nine ? 4'd8 : 4'd7;
  assign ilim     = cfg_nine ? IW'(OSR * 11) : IW'(OSR * 10);
  assign keep_old = flag_full & ~rd_data;
  assign par_bad  = cfg_par_en & ((^word) != cfg_par_odd);

  assign irq_rx  = (flag_full & en_full) | (flag_idle & en_idle);
  assign irq_err = (flag_ovr & en_ovr) | (flag_noise & en_noise) |
                   (flag_frame & en_frame) | (flag_par & en_par);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= HUNT;
      cnt        <= '0;
      bitn       <= '0;
      sh         <= '0;
      icnt       <= '0;
      s_lo       <= 1'b1;
      s_mid      <= 1'b1;
      prev       <= 1'b1;
      nz_acc     <= 1'b0;
      armed      <= 1'b0;
      rx_data    <= '0;
      flag_full  <= 1'b0;
      flag_idle  <= 1'b0;
      flag_ovr   <= 1'b0;
      flag_noise <= 1'b0;
      flag_frame <= 1'b0;
      flag_par   <= 1'b0;
    end else begin
      if (rd_data) begin
        flag_full  <= 1'b0;
        flag_ovr   <= 1'b0;
        flag_noise <= 1'b0;
        flag_frame <= 1'b0;
        flag_par   <= 1'b0;
      end
      if (clr_stat) begin
        flag_idle  <= 1'b0;
        flag_ovr   <= 1'b0;
        flag_noise <= 1'b0;
        flag_frame <= 1'b0;
        flag_par   <= 1'b0;
      end
      if (os_tick) begin
        prev <= rx_s;

        if (st == HUNT && rx_s) begin
          if (icnt != ilim) icnt <= icnt + 1'b1;
          if (armed && icnt == ilim - 1'b1) begin
            flag_idle <= 1'b1;
            armed     <= 1'b0;
          end
        end else begin
          icnt <= '0;
        end

        if (st == HUNT) begin
          if (prev && !rx_s) begin
            st     <= START;
            cnt    <= CW'(1);
            nz_acc <= 1'b0;
          end
        end else begin
          cnt <= (cnt == C_TOP) ? '0 : cnt + 1'b1;
          if (cnt == C_LO)  s_lo  <= rx_s;
          if (cnt == C_MID) s_mid <= rx_s;
          if (at_dec) begin
            case (st)
              START: begin
                if (maj) st <= HUNT;
                else begin
                  st     <= DATA;
                  bitn   <= '0;
                  nz_acc <= nz;
                end
              end
              DATA: begin
                sh     <= {maj, sh[8:1]};
                nz_acc <= nz_acc | nz;
                bitn   <= bitn + 1'b1;
                if (bitn == last_bit) st <= STOP;
              end
              default: begin
                st    <= HUNT;
                armed <= 1'b1;
                if (keep_old) begin
                  flag_ovr <= 1'b1;
                end else begin
                  rx_data    <= word;
                  flag_full  <= 1'b1;
                  flag_noise <= nz_acc | nz;
                  flag_frame <= ~maj;
                  flag_par   <= par_bad;
                end
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       os_tick,
  input logic       rd_data,
  input logic       clr_stat,
  input logic [8:0] rx_data,
  input logic       flag_full,
  input logic       flag_idle,
  input logic       flag_ovr,
  input logic       flag_noise,
  input logic       flag_frame,
  input logic       flag_par,
  input logic       irq_rx,
  input logic       irq_err
);
  a_r1_full_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_full) |-> $past(os_tick));

  a_r2_rx_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (flag_full || flag_idle));

  a_r3_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_full && !rd_data) |=> $stable(rx_data));

  a_r8_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_idle && !clr_stat) |=> flag_idle);

  a_r10_err_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (flag_ovr || flag_noise || flag_frame || flag_par));

  a_r11_read_clears_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data |=> !flag_ovr);

  a_r11_clr_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !rd_data && flag_full) |=> flag_full);
endmodule

bind uart_rx_err uart_rx_err_chk u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rd_data(rd_data),
  .clr_stat(clr_stat), .rx_data(rx_data), .flag_full(flag_full),
  .flag_idle(flag_idle), .flag_ovr(flag_ovr), .flag_noise(flag_noise),
  .flag_frame(flag_frame), .flag_par(flag_par), .irq_rx(irq_rx),
  .irq_err(irq_err)
);

// File: tb/uart_rx_err_bench.sv
module uart_rx_err_bench;
  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [1:0] tdiv = 2'd0;
  logic os_tick;
  logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic en_full = 1'b1, en_idle = 1'b0, en_ovr = 1'b1;
  logic en_noise = 1'b1, en_frame = 1'b1, en_par = 1'b1;
  logic rd_data = 1'b0, clr_stat = 1'b0;
  logic [8:0] rx_data;
  logic flag_full, flag_idle, flag_ovr, flag_noise, flag_frame, flag_par;
  logic irq_rx, irq_err;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  uart_rx_err u_uart_rx_err (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .os_tick(os_tick),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .en_full(en_full), .en_idle(en_idle), .en_ovr(en_ovr),
    .en_noise(en_noise), .en_frame(en_frame), .en_par(en_par),
    .rd_data(rd_data), .clr_stat(clr_stat), .rx_data(rx_data),
    .flag_full(flag_full), .flag_idle(flag_idle), .flag_ovr(flag_ovr),
    .flag_noise(flag_noise), .flag_frame(flag_frame), .flag_par(flag_par),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  typedef struct {
    logic [8:0] d;
    logic nz, fe, pe, ov;
  } exp_t;
  exp_t q[$];

  int n_vec = 0, n_bad = 0;
  bit done = 0, auto_rd = 1, rd_req = 0;

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // scoreboard monitor: owns rd_data
  always @(negedge clk) begin
    rd_data <= 1'b0;
    if (rd_req) begin
      rd_data <= 1'b1;
      rd_req = 0;
    end else if (auto_rd && flag_full && !rd_data) begin
      if (q.size() == 0) begin
        chk("R1 unexpected character", 9'd1, 9'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R1 data", rx_data, e.d);
        chk("R4 noise", {8'd0, flag_noise}, {8'd0, e.nz});
        chk("R6 frame", {8'd0, flag_frame}, {8'd0, e.fe});
        chk("R7 parity", {8'd0, flag_par}, {8'd0, e.pe});
        chk("R3 overrun", {8'd0, flag_ovr}, {8'd0, e.ov});
      end
      rd_data <= 1'b1;
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!os_tick);
  endtask

  task automatic send_bit(input logic v, input int g_lo, input int g_hi);
    for (int i = 0; i < 16; i++) begin
      wait_tick();
      rx = (i >= g_lo && i <= g_hi) ? ~v : v;
    end
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wait_tick();
      rx = 1'b1;
    end
  endtask

  // gbit: 0 start, 1..n character bits, n+1 stop; glitch at slot 8
  task automatic send_frame(input logic [8:0] w, input logic nine,
                            input logic stopv, input int gbit);
    int n;
    n = nine ? 9 : 8;
    send_bit(1'b0, gbit == 0 ? 8 : 99, 8);
    for (int b = 0; b < n; b++) send_bit(w[b], gbit == b + 1 ? 8 : 99, 8);
    send_bit(stopv, gbit == n + 1 ? 8 : 99, 8);
    rx = 1'b1;
  endtask

  // driver: push expectation, then send
  task automatic drive(input logic [8:0] w, input logic nine, input logic stopv,
                       input int gbit, input logic pe);
    exp_t e;
    e.d = nine ? w : {1'b0, w[7:0]};
    e.nz = (gbit >= 0);
    e.fe = ~stopv;
    e.pe = pe;
    e.ov = 1'b0;
    q.push_back(e);
    send_frame(w, nine, stopv, gbit);
    if (!stopv) idle_ticks(16);
  endtask

  function automatic logic [8:0] with_par(input logic [8:0] d, input logic nine,
                                          input logic odd);
    if (nine) return {^d[7:0] ^ odd, d[7:0]};
    return {1'b0, ^d[6:0] ^ odd, d[6:0]};
  endfunction

  task automatic pulse_clr();
    @(negedge clk) clr_stat = 1'b1;
    @(negedge clk) clr_stat = 1'b0;
  endtask

  task automatic manual_read();
    rd_req = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset full", {8'd0, flag_full}, 9'd0);
    chk("R1 reset data", rx_data, 9'd0);
    chk("R8 reset idle", {8'd0, flag_idle}, 9'd0);
    chk("R2 reset irq_rx", {8'd0, irq_rx}, 9'd0);
    chk("R10 reset irq_err", {8'd0, irq_err}, 9'd0);
    idle_ticks(20);

    // R1: 8-bit and 9-bit characters
    drive(9'h055, 0, 1, -1, 0);
    drive(9'h0A3, 0, 1, -1, 0);
    drive(9'h000, 0, 1, -1, 0);
    drive(9'h0FF, 0, 1, -1, 0);
    cfg_nine = 1'b1;
    drive(9'h1A5, 1, 1, -1, 0);
    drive(9'h0C3, 1, 1, -1, 0);
    cfg_nine = 1'b0;

    // R7: parity, both senses, both widths
    cfg_par_en = 1'b1;
    drive(with_par(9'h035, 0, 0), 0, 1, -1, 0);
    drive(with_par(9'h035, 0, 0) ^ 9'h080, 0, 1, -1, 1);
    cfg_par_odd = 1'b1;
    drive(with_par(9'h062, 0, 1), 0, 1, -1, 0);
    drive(with_par(9'h062, 0, 1) ^ 9'h001, 0, 1, -1, 1);
    cfg_nine = 1'b1;
    drive(with_par(9'h0E7, 1, 1), 1, 1, -1, 0);
    drive(with_par(9'h0E7, 1, 1) ^ 9'h100, 1, 1, -1, 1);
    cfg_nine = 1'b0;
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // R4: mid-sample glitches in start, data and stop bits
    drive(9'h03C, 0, 1, 0, 0);
    drive(9'h03C, 0, 1, 4, 0);
    drive(9'h0C1, 0, 1, 9, 0);

    // R6: framing error and break
    drive(9'h012, 0, 0, -1, 0);
    drive(9'h000, 0, 0, -1, 0);

    // R5: rejected start
    send_bit(1'b0, 3, 15);
    idle_ticks(20);
    chk("R5 no character from short low", {8'd0, flag_full}, 9'd0);
    drive(9'h09E, 0, 1, -1, 0);

    // R3: overrun
    auto_rd = 0;
    begin
      exp_t e;
      e.d = 9'h031; e.nz = 0; e.fe = 0; e.pe = 0; e.ov = 1;
      q.push_back(e);
    end
    send_frame(9'h031, 0, 1, -1);
    send_frame(9'h04C, 0, 1, -1);
    chk("R3 overrun flag", {8'd0, flag_ovr}, 9'd1);
    chk("R3 earlier character kept", rx_data, 9'h031);
    chk("R10 overrun irq", {8'd0, irq_err}, 9'd1);
    auto_rd = 1;
    repeat (3) @(negedge clk);
    chk("R11 read clears overrun", {8'd0, flag_ovr}, 9'd0);

    // R2, R10, R11: manual flag handling
    auto_rd = 0;
    en_ovr = 0; en_noise = 0; en_frame = 0; en_par = 0; en_full = 0;
    send_frame(9'h012, 0, 0, -1);
    idle_ticks(16);
    chk("R6 manual frame flag", {8'd0, flag_frame}, 9'd1);
    chk("R10 error irq masked", {8'd0, irq_err}, 9'd0);
    chk("R2 rx irq masked", {8'd0, irq_rx}, 9'd0);
    en_frame = 1;
    @(negedge clk);
    chk("R10 framing irq enabled", {8'd0, irq_err}, 9'd1);
    en_full = 1;
    @(negedge clk);
    chk("R2 rx irq on full", {8'd0, irq_rx}, 9'd1);
    pulse_clr();
    @(negedge clk);
    chk("R11 clear drops frame flag", {8'd0, flag_frame}, 9'd0);
    chk("R11 clear keeps full", {8'd0, flag_full}, 9'd1);
    chk("R11 clear keeps data", rx_data, 9'h012);
    chk("R10 error irq after clear", {8'd0, irq_err}, 9'd0);
    manual_read();
    chk("R11 read clears full", {8'd0, flag_full}, 9'd0);
    chk("R2 rx irq after read", {8'd0, irq_rx}, 9'd0);
    en_ovr = 1; en_noise = 1; en_par = 1;
    auto_rd = 1;

    // R8: idle detection, 8-bit
    en_idle = 1;
    pulse_clr();
    drive(9'h077, 0, 1, -1, 0);
    idle_ticks(140);
    chk("R8 idle not yet", {8'd0, flag_idle}, 9'd0);
    idle_ticks(25);
    chk("R8 idle set 8-bit", {8'd0, flag_idle}, 9'd1);
    chk("R2 idle irq", {8'd0, irq_rx}, 9'd1);
    en_idle = 0;
    @(negedge clk);
    chk("R2 idle irq masked", {8'd0, irq_rx}, 9'd0);

    // R9: no re-arm without a character; zero restarts count
    pulse_clr();
    idle_ticks(200);
    chk("R9 idle stays clear", {8'd0, flag_idle}, 9'd0);
    drive(9'h0A0, 0, 1, -1, 0);
    idle_ticks(100);
    send_bit(1'b0, 3, 15);
    idle_ticks(90);
    chk("R9 zero restarted idle count", {8'd0, flag_idle}, 9'd0);
    idle_ticks(80);
    chk("R9 idle after restart", {8'd0, flag_idle}, 9'd1);

    // R8: 9-bit idle length
    cfg_nine = 1'b1;
    pulse_clr();
    drive(9'h10F, 1, 1, -1, 0);
    idle_ticks(160);
    chk("R8 idle not yet 9-bit", {8'd0, flag_idle}, 9'd0);
    idle_ticks(20);
    chk("R8 idle set 9-bit", {8'd0, flag_idle}, 9'd1);

    chk("R1 all characters seen", 9'(q.size()), 9'd0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end
endmodule